// File: doc/BRIEF.md
# Pixel Readout Address Sequencer

This block generates the stream of row and column addresses that steers the row-select scanner and the column multiplexer of a pixel array in which any pixel can be addressed directly. One address leaves the block per clock cycle, and a valid strobe qualifies it. Two flags mark the last address of a scanned row and the last address of the frame. A third flag marks the first pixel of each binning group.

The scan pattern comes from a small register set written through a plain write port. The patterns are:

- the whole array;
- a rectangular region of interest with a programmable origin and size;
- a decimated scan with separate power-of-two steps for rows and columns;
- square binning groups of 2x2 or 4x4 pixels, with the pixels of each group sent back to back;
- random access, in which addresses pushed into a 16-entry queue are sent in the order they were pushed.

A one-cycle `start` pulse launches a programmed frame. In random mode the queue drains on its own, one entry per cycle.

Top module: `pix_addr_seq`

## Requirements
- R1: Mode value 0 (register 0, bits [2:0]) scans every pixel exactly once, row-major, from (0,0) to (ROWS-1,COLS-1). Addresses go out on consecutive cycles, and the first one is valid in the second cycle after the cycle in which `start` is sampled high.
- R2: Mode 1 scans only the rectangle whose first row is register 1, first column register 2, height register 3 and width register 4, row-major. A height or width of 0 counts as 1.
- R3: In mode 1, an origin beyond the array is clamped to the last row or column, and a rectangle that extends past the array edge is cut off at the edge.
- R4: Mode 2 scans the whole array with a row step of 2^k and a column step of 2^m, starting at (0,0). k is register 5 bits [1:0] and m is register 5 bits [3:2], so each step ranges from 1 to 8.
- R5: Mode 3 tiles the array into BxB groups, with B=2 when register 6 bit 0 is 0 and B=4 when it is 1. Groups are visited row-major. The B*B pixels of a group go out back to back, row-major inside the group, and `out_grp_start` is high on the first pixel of each group only.
- R6: Mode 4 pops one queued address per cycle and outputs it, in push order. `out_valid` is low whenever the queue is empty.
- R7: The queue holds 16 entries, and `rnd_full` is high when it holds 16. A push while the queue is full is dropped.
- R8: `out_line_end` is high with the last address of each scanned row, and `out_frame_end` with the last address of the frame. In binning mode a row is a row of groups, so `out_line_end` goes with the last pixel of the last group in that row. Neither flag, nor `out_grp_start`, is ever high in random mode.
- R9: Once a frame has ended, `out_valid` stays low until the next `start`. A `start` pulse is ignored while a frame is in progress and while mode 4 is selected.
- R10: After reset, `out_valid`, all the flags and `rnd_full` are low. The mode is full frame and the window covers the whole array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 mode, 1 window row, 2 window column, 3 height, 4 width, 5 step exponents, 6 bin size) |
| cfg_wdata | input | DW | Register write data |
| start | input | 1 | Launch one programmed frame |
| rnd_push | input | 1 | Push one random address into the queue |
| rnd_row | input | RW | Row of the pushed address |
| rnd_col | input | CW | Column of the pushed address |
| rnd_full | output | 1 | Queue holds 16 entries |
| out_valid | output | 1 | Address outputs are valid this cycle |
| out_row | output | RW | Row address |
| out_col | output | CW | Column address |
| out_grp_start | output | 1 | First pixel of a binning group |
| out_line_end | output | 1 | Last address of a row |
| out_frame_end | output | 1 | Last address of the frame |

## Verification
A wrong scan counter shows up at the ports as a wrong address or a misplaced row-end flag within one row of the cycle where the state went wrong. Every frame is compared address by address against a sequence computed arithmetically. A bad wrap decision shows up in one of two ways: the frame fails to end, which shows as an extra address, or it ends early, which shows as a missing address and a premature frame-end flag. A queue pointer or count fault shows up as reordered, repeated or lost random addresses within the next 16 pops, or as `rnd_full` asserting at the wrong fill level.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;

  typedef enum logic [2:0] {
    SCAN_FULL = 3'd0,
    SCAN_WIN  = 3'd1,
    SCAN_SUB  = 3'd2,
    SCAN_BIN  = 3'd3,
    SCAN_RAND = 3'd4
  } scan_mode_e;

  localparam logic [2:0] REG_MODE   = 3'd0;
  localparam logic [2:0] REG_WROW   = 3'd1;
  localparam logic [2:0] REG_WCOL   = 3'd2;
  localparam logic [2:0] REG_WHGT   = 3'd3;
  localparam logic [2:0] REG_WWID   = 3'd4;
  localparam logic [2:0] REG_STEP   = 3'd5;
  localparam logic [2:0] REG_BIN    = 3'd6;

endpackage

// File: rtl/pix_seq_cfg.sv
module pix_seq_cfg
  import pix_seq_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int DW   = 16,
  parameter int RXW  = 8,
  parameter int CXW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [RXW-1:0] r_first,
  output logic [RXW-1:0] r_last,
  output logic [RXW-1:0] r_step,
  output logic [CXW-1:0] c_first,
  output logic [CXW-1:0] c_last,
  output logic [CXW-1:0] c_step,
  output logic [1:0]     bsz_m1,
  output logic           bin_en,
  output logic           rand_en
);

  localparam logic [DW-1:0] RMAX = DW'(ROWS - 1);
  localparam logic [DW-1:0] CMAX = DW'(COLS - 1);

  logic [2:0]    mode_q;
  logic [DW-1:0] wrow_q, wcol_q, whgt_q, wwid_q;
  logic [1:0]    rexp_q, cexp_q;
  logic          bin4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SCAN_FULL;
      wrow_q <= '0;
      wcol_q <= '0;
      whgt_q <= DW'(ROWS);
      wwid_q <= DW'(COLS);
      rexp_q <= '0;
      cexp_q <= '0;
      bin4_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_MODE: mode_q <= cfg_wdata[2:0];
        REG_WROW: wrow_q <= cfg_wdata;
        REG_WCOL: wcol_q <= cfg_wdata;
        REG_WHGT: whgt_q <= cfg_wdata;
        REG_WWID: wwid_q <= cfg_wdata;
        REG_STEP: begin
          rexp_q <= cfg_wdata[1:0];
          cexp_q <= cfg_wdata[3:2];
        end
        REG_BIN:  bin4_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  // Window clipping: clamp the origin, treat a zero size as one, cut at the edge.
  logic [DW-1:0] wr0, wc0, hm1, wm1;
  logic [DW:0]   rend, cend;
  logic [DW-1:0] rlim, clim;

  always_comb begin
    wr0  = (wrow_q > RMAX) ? RMAX : wrow_q;
    wc0  = (wcol_q > CMAX) ? CMAX : wcol_q;
    hm1  = (whgt_q == '0) ? '0 : whgt_q - 1'b1;
    wm1  = (wwid_q == '0) ? '0 : wwid_q - 1'b1;
    rend = {1'b0, wr0} + {1'b0, hm1};
    cend = {1'b0, wc0} + {1'b0, wm1};
    rlim = (rend > {1'b0, RMAX}) ? RMAX : rend[DW-1:0];
    clim = (cend > {1'b0, CMAX}) ? CMAX : cend[DW-1:0];
  end

  always_comb begin
    r_first = '0;
    c_first = '0;
    r_last  = RXW'(ROWS - 1);
    c_last  = CXW'(COLS - 1);
    r_step  = RXW'(1);
    c_step  = CXW'(1);
    bsz_m1  = 2'd0;
    bin_en  = 1'b0;
    rand_en = 1'b0;
    case (mode_q)
      SCAN_WIN: begin
        r_first = RXW'(wr0);
        c_first = CXW'(wc0);
        r_last  = RXW'(rlim);
        c_last  = CXW'(clim);
      end
      SCAN_SUB: begin
        r_step = RXW'(1) << rexp_q;
        c_step = CXW'(1) << cexp_q;
      end
      SCAN_BIN: begin
        bin_en = 1'b1;
        bsz_m1 = bin4_q ? 2'd3 : 2'd1;
        r_step = bin4_q ? RXW'(4) : RXW'(2);
        c_step = bin4_q ? CXW'(4) : CXW'(2);
      end
      SCAN_RAND: rand_en = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/pix_seq_scan.sv
module pix_seq_scan #(
  parameter int RW  = 4,
  parameter int CW  = 4,
  parameter int RXW = 8,
  parameter int CXW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [RXW-1:0] r_first,
  input  logic [RXW-1:0] r_last,
  input  logic [RXW-1:0] r_step,
  input  logic [CXW-1:0] c_first,
  input  logic [CXW-1:0] c_last,
  input  logic [CXW-1:0] c_step,
  input  logic [1:0]     bsz_m1,
  input  logic           bin_en,
  input  logic           rand_en,
  output logic           busy,
  output logic [RW-1:0]  cur_row,
  output logic [CW-1:0]  cur_col,
  output logic           grp_first,
  output logic           line_last,
  output logic           frame_last
);

  logic [RXW-1:0] base_r;
  logic [CXW-1:0] base_c;
  logic [1:0]     off_r, off_c;
  logic           c_wrap, r_wrap, grp_done;

  assign c_wrap   = (base_c + c_step) > c_last;
  assign r_wrap   = (base_r + r_step) > r_last;
  assign grp_done = (off_r == bsz_m1) && (off_c == bsz_m1);

  assign cur_row    = RW'(base_r + RXW'(off_r));
  assign cur_col    = CW'(base_c + CXW'(off_c));
  assign grp_first  = bin_en && (off_r == 2'd0) && (off_c == 2'd0);
  assign line_last  = grp_done && c_wrap;
  assign frame_last = line_last && r_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      base_r <= '0;
      base_c <= '0;
      off_r  <= '0;
      off_c  <= '0;
    end else if (!busy) begin
      if (start && !rand_en) begin
        busy   <= 1'b1;
        base_r <= r_first;
        base_c <= c_first;
        off_r  <= '0;
        off_c  <= '0;
      end
    end else if (off_c != bsz_m1) begin
      off_c <= off_c + 2'd1;
    end else if (off_r != bsz_m1) begin
      off_c <= '0;
      off_r <= off_r + 2'd1;
    end else begin
      off_c <= '0;
      off_r <= '0;
      if (!c_wrap) begin
        base_c <= base_c + c_step;
      end else begin
        base_c <= c_first;
        if (r_wrap) busy <= 1'b0;
        else        base_r <= base_r + r_step;
      end
    end
  end

  a_r9_base_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (base_r <= r_last) && (base_c <= c_last));

  a_r9_no_early_stop: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_last) |=> busy);

endmodule

// File: rtl/pix_seq_fifo.sv
module pix_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));

  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/pix_addr_seq.sv
module pix_addr_seq #(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int DW    = 16,
  parameter int QDEPTH = 16,
  parameter int RW    = $clog2(ROWS),
  parameter int CW    = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          start,
  input  logic          rnd_push,
  input  logic [RW-1:0] rnd_row,
  input  logic [CW-1:0] rnd_col,
  output logic          rnd_full,
  output logic          out_valid,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          out_grp_start,
  output logic          out_line_end,
  output logic          out_frame_end
);

  localparam int RXW = RW + 4;
  localparam int CXW = CW + 4;

  logic [RXW-1:0] r_first, r_last, r_step;
  logic [CXW-1:0] c_first, c_last, c_step;
  logic [1:0]     bsz_m1;
  logic           bin_en, rand_en;

  pix_seq_cfg #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RXW(RXW), .CXW(CXW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .r_first(r_first), .r_last(r_last), .r_step(r_step),
    .c_first(c_first), .c_last(c_last), .c_step(c_step),
    .bsz_m1(bsz_m1), .bin_en(bin_en), .rand_en(rand_en)
  );

  logic          scan_busy, grp_first, line_last, frame_last;
  logic [RW-1:0] scan_row;
  logic [CW-1:0] scan_col;

  pix_seq_scan #(.RW(RW), .CW(CW), .RXW(RXW), .CXW(CXW)) u_scan (
    .clk(clk), .rst(rst), .start(start),
    .r_first(r_first), .r_last(r_last), .r_step(r_step),
    .c_first(c_first), .c_last(c_last), .c_step(c_step),
    .bsz_m1(bsz_m1), .bin_en(bin_en), .rand_en(rand_en),
    .busy(scan_busy), .cur_row(scan_row), .cur_col(scan_col),
    .grp_first(grp_first), .line_last(line_last), .frame_last(frame_last)
  );

  logic [RW+CW-1:0] q_dout;
  logic             q_empty, q_pop;

  assign q_pop = !scan_busy && rand_en && !q_empty;

  pix_seq_fifo #(.W(RW + CW), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(rnd_push), .din({rnd_row, rnd_col}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(rnd_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_row       <= '0;
      out_col       <= '0;
      out_grp_start <= 1'b0;
      out_line_end  <= 1'b0;
      out_frame_end <= 1'b0;
    end else begin
      out_valid     <= 1'b0;
      out_grp_start <= 1'b0;
      out_line_end  <= 1'b0;
      out_frame_end <= 1'b0;
      if (scan_busy) begin
        out_valid     <= 1'b1;
        out_row       <= scan_row;
        out_col       <= scan_col;
        out_grp_start <= grp_first;
        out_line_end  <= line_last;
        out_frame_end <= frame_last;
      end else if (q_pop) begin
        out_valid <= 1'b1;
        out_row   <= q_dout[RW+CW-1:CW];
        out_col   <= q_dout[CW-1:0];
      end
    end
  end

  a_r8_frame_in_line: assert property (@(posedge clk) disable iff (rst)
    out_frame_end |-> (out_line_end && out_valid));

  a_r5_grp_not_line_end: assert property (@(posedge clk) disable iff (rst)
    out_grp_start |-> (out_valid && !out_line_end));

  a_r6_empty_no_valid: assert property (@(posedge clk) disable iff (rst)
    (!scan_busy && q_empty) |=> !out_valid);

endmodule

// File: tb/pix_addr_seq_bench.sv
`timescale 1ns/1ps
module pix_addr_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic       start = 1'b0;
  logic       rnd_push = 1'b0;
  logic [3:0] rnd_row = '0, rnd_col = '0;
  logic       rnd_full, out_valid, out_grp_start, out_line_end, out_frame_end;
  logic [3:0] out_row, out_col;

  always #5 clk = ~clk;

  pix_addr_seq u_pix_addr_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .rnd_push(rnd_push), .rnd_row(rnd_row), .rnd_col(rnd_col),
    .rnd_full(rnd_full), .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
    .out_grp_start(out_grp_start), .out_line_end(out_line_end), .out_frame_end(out_frame_end)
  );

  int checks = 0;
  int errors = 0;

  int exp_r [0:255];
  int exp_c [0:255];
  int exp_g [0:255];
  int exp_l [0:255];
  int exp_f [0:255];
  int nexp;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic add(input int r, input int c, input int g, input int l, input int f);
    exp_r[nexp] = r; exp_c[nexp] = c; exp_g[nexp] = g; exp_l[nexp] = l; exp_f[nexp] = f;
    nexp++;
  endtask

  task automatic gen_raster(input int r0, input int rl, input int rs,
                            input int c0, input int cl, input int cs);
    nexp = 0;
    for (int r = r0; r <= rl; r += rs)
      for (int c = c0; c <= cl; c += cs)
        add(r, c, 0, int'(c + cs > cl), int'((c + cs > cl) && (r + rs > rl)));
  endtask

  task automatic gen_bin(input int b);
    nexp = 0;
    for (int gr = 0; gr < 16; gr += b)
      for (int gc = 0; gc < 16; gc += b)
        for (int orr = 0; orr < b; orr++)
          for (int oc = 0; oc < b; oc++) begin
            int le;
            le = int'((orr == b - 1) && (oc == b - 1) && (gc + b > 15));
            add(gr + orr, gc + oc, int'(orr == 0 && oc == 0), le, int'(le != 0 && gr + b > 15));
          end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Launch a frame and compare every valid output against the expected list.
  task automatic run_frame(input string req, input int restart_at);
    int got;
    got = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < nexp + 8; cyc++) begin
      @(negedge clk);
      if (out_valid) begin
        if (got < nexp) begin
          chk(out_row == 4'(exp_r[got]) && out_col == 4'(exp_c[got]), req, "address",
              int'({out_row, out_col}), (exp_r[got] << 4) | exp_c[got]);
          chk(out_line_end == exp_l[got][0] && out_frame_end == exp_f[got][0], "R8", "row/frame end",
              int'({out_line_end, out_frame_end}), (exp_l[got] << 1) | exp_f[got]);
          chk(out_grp_start == exp_g[got][0], "R5", "group start", int'(out_grp_start), exp_g[got]);
        end else begin
          chk(1'b0, "R9", "extra address after frame", got, nexp);
        end
        got++;
      end
      start = (cyc == restart_at);
    end
    start = 1'b0;
    chk(got == nexp, req, "address count", got, nexp);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_window(input int r0, input int c0, input int h, input int w, input string req);
    int rf, cf;
    rf = imin(r0, 15);
    cf = imin(c0, 15);
    wr(3'd1, r0); wr(3'd2, c0); wr(3'd3, h); wr(3'd4, w);
    gen_raster(rf, imin(rf + ((h == 0) ? 1 : h) - 1, 15), 1,
               cf, imin(cf + ((w == 0) ? 1 : w) - 1, 15), 1);
    run_frame(req, -1);
  endtask

  task automatic push(input int r, input int c);
    @(negedge clk);
    rnd_push = 1'b1; rnd_row = 4'(r); rnd_col = 4'(c);
    @(negedge clk);
    rnd_push = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!out_valid && !out_line_end && !out_frame_end && !out_grp_start && !rnd_full,
        "R10", "reset outputs", int'({out_valid, out_line_end, out_frame_end, out_grp_start, rnd_full}), 0);

    // R1 full frame with default registers; R9 restart pulse mid-frame is ignored
    gen_raster(0, 15, 1, 0, 15, 1);
    run_frame("R1", 40);

    // R2 window, zero size; R3 clipping and origin clamp
    wr(3'd0, 1);
    run_window(2, 3, 4, 5, "R2");
    run_window(7, 9, 0, 0, "R2");
    run_window(12, 10, 8, 9, "R3");
    run_window(20, 30, 3, 2, "R3");

    // R4 all step combinations
    wr(3'd0, 2);
    for (int kr = 0; kr < 4; kr++)
      for (int kc = 0; kc < 4; kc++) begin
        wr(3'd5, (kc << 2) | kr);
        gen_raster(0, 15, 1 << kr, 0, 15, 1 << kc);
        run_frame("R4", -1);
      end

    // R5 binning 2x2 and 4x4
    wr(3'd0, 3);
    wr(3'd6, 0); gen_bin(2); run_frame("R5", -1);
    wr(3'd6, 1); gen_bin(4); run_frame("R5", -1);

    // R6 random access: fill while idle in full mode, then drain
    wr(3'd0, 0);
    for (int i = 0; i < 5; i++) push((i * 7 + 3) % 16, (i * 5 + 11) % 16);
    wr(3'd0, 4);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k < 5)
        chk(out_valid && out_row == 4'((k * 7 + 3) % 16) && out_col == 4'((k * 5 + 11) % 16)
            && !out_line_end && !out_frame_end && !out_grp_start,
            "R6", "random pop", int'({out_valid, out_row, out_col}),
            (1 << 8) | (((k * 7 + 3) % 16) << 4) | ((k * 5 + 11) % 16));
      else
        chk(!out_valid, "R6", "valid low when empty", int'(out_valid), 0);
    end

    // R9 start ignored in random mode
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!out_valid, "R9", "start in random mode", int'(out_valid), 0);
    end

    // R7 queue depth and drop on full
    wr(3'd0, 0);
    for (int i = 0; i < 18; i++) begin
      push(i % 16, 15 - (i % 16));
      chk(rnd_full == (i >= 15), "R7", "full flag", int'(rnd_full), int'(i >= 15));
    end
    wr(3'd0, 4);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k < 16)
        chk(out_valid && out_row == 4'(k) && out_col == 4'(15 - k), "R7", "queued entry",
            int'({out_valid, out_row, out_col}), (1 << 8) | (k << 4) | (15 - k));
      else
        chk(!out_valid, "R7", "dropped pushes absent", int'(out_valid), 0);
    end
    chk(!rnd_full, "R7", "full clears after drain", int'(rnd_full), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule